// File: doc/BRIEF.md
# Page-Granular Access Protection Monitor

This block watches a CPU's memory accesses and checks each one against four programmable guarded ranges. A range is a span of whole 1 KB pages, given by an inclusive first page and last page. The page number of an access is its physical address shifted right by ten bits. Each range has a two-bit permission field. One bit forbids reads and the other forbids writes.

When an observed access falls inside a range whose permission forbids that kind of access, the block sets that range's status flag. It also records the faulting address in two halfword registers, unless an earlier fault is still outstanding. A single interrupt output is raised for any flagged range whose own enable, or the global enable, is set. The block only observes accesses. It never stalls or cancels them. Software configures and services it through a 16-bit register port with registered read data.

Top module: `pgprot_monitor`

## Requirements
- R1: After a synchronous reset, every range, permission, enable, status and fault-address register reads 0 and `irq_o` is 0.
- R2: Range k has a read/write 16-bit first-page register at byte offset 4k and a read/write 16-bit last-page register at offset 4k+2.
- R3: An access hits range k when first ≤ (address >> 10) ≤ last. The full page number is compared, so address bits above the 16-bit page span must be zero for a hit. Both bounds are inclusive.
- R4: The permission register at offset 0x10 holds field k in bits [2k+1:2k]. Field bit 0 forbids reads and field bit 1 forbids writes, so 00 disables checking for range k. Bits 15:8 read as 0 and ignore writes.
- R5: An access with `acc_valid` high, `acc_write` selecting a write (1) or a read (0), that hits a range forbidding that kind sets status bit k (offset 0x1E) at the clock edge that samples the access. Every offending range is flagged together. Accesses with `acc_valid` low have no effect.
- R6: Status bit 4 reads as the OR of bits 3:0. Writing 1 to bit k (0..3) clears that bit, writing 1 to bit 4 clears all bits, and writing 0 leaves bits unchanged.
- R7: When a violation occurs while all status bits are 0, offset 0x22 captures {address[15:5], 5'b0} and offset 0x24 captures {2'b0, address[29:16]}. At any other time both registers hold their value, and writes to them are ignored.
- R8: The enable register at offset 0x1C holds bits 4:0. Bit k enables range k's interrupt and bit 4 enables all ranges. Bits 15:5 read as 0.
- R9: `irq_o` is a registered output. It rises one clock after a status bit becomes set while that bit's enable or the global enable is set, and it falls one clock after no enabled status bit remains.
- R10: `reg_rdata` is updated at the clock edge that samples `reg_rd` and shows the register values from before that edge. Unassigned offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 16 | Registered read data |
| acc_valid | input | 1 | Observed access present this cycle |
| acc_write | input | 1 | Observed access is a write (1) or a read (0) |
| acc_addr | input | 32 | Observed physical byte address |
| irq_o | output | 1 | Combined protection interrupt |

## Verification
A status flag and the fault address are due at the same edge that samples the access. Read data for them is due one edge after the read strobe, so the bench reads status only after the access cycle has ended. `irq_o` lags the status flag by exactly one edge. The bench checks it low at the first falling edge after the offending access and high at the next one, and it checks the same one-cycle lag when the flag is cleared. All inputs change on falling edges, and all outputs are sampled on falling edges, half a period away from the edges that update them.

// File: rtl/pgprot_pkg.sv
package pgprot_pkg;

  localparam int REG_ADDR_W = 6;

  localparam logic [REG_ADDR_W-1:0] OFS_PERM  = 6'h10;
  localparam logic [REG_ADDR_W-1:0] OFS_IEN   = 6'h1C;
  localparam logic [REG_ADDR_W-1:0] OFS_FLAG  = 6'h1E;
  localparam logic [REG_ADDR_W-1:0] OFS_FADLO = 6'h22;
  localparam logic [REG_ADDR_W-1:0] OFS_FADHI = 6'h24;

  // fault address field positions
  localparam int FLO_LSB = 5;
  localparam int FLO_MSB = 15;
  localparam int FHI_LSB = 16;
  localparam int FHI_MSB = 29;

  typedef struct packed {
    logic no_wr;
    logic no_rd;
  } perm_t;

  function automatic logic [REG_ADDR_W-1:0] first_ofs(input int k);
    return REG_ADDR_W'(4 * k);
  endfunction

  function automatic logic [REG_ADDR_W-1:0] last_ofs(input int k);
    return REG_ADDR_W'(4 * k + 2);
  endfunction

endpackage

// File: rtl/pgprot_range_match.sv
module pgprot_range_match
  import pgprot_pkg::*;
#(
  parameter int PAGE_W = 22,
  parameter int REG_W  = 16
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [REG_W-1:0]  first_i,
  input  logic [REG_W-1:0]  last_i,
  input  perm_t             perm_i,
  input  logic              valid_i,
  input  logic              write_i,
  output logic              viol_o
);

  logic in_span;
  logic denied;

  // zero-extend bounds so page bits above the bound width must be zero
  assign in_span = (PAGE_W'(first_i) <= page_i) && (page_i <= PAGE_W'(last_i));
  assign denied  = write_i ? perm_i.no_wr : perm_i.no_rd;
  assign viol_o  = valid_i && in_span && denied;

endmodule

// File: rtl/pgprot_fault_log.sv
module pgprot_fault_log
  import pgprot_pkg::*;
#(
  parameter int NUM_RGN = 4,
  parameter int ADDR_W  = 32,
  parameter int REG_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_RGN-1:0] viol_i,
  input  logic [NUM_RGN-1:0] clr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_RGN-1:0] flag_q,
  output logic [REG_W-1:0]   fad_lo_q,
  output logic [REG_W-1:0]   fad_hi_q
);

  localparam int LO_W = FLO_MSB - FLO_LSB + 1;

  logic capture;

  assign capture = (|viol_i) && (flag_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= '0;
      fad_lo_q <= '0;
      fad_hi_q <= '0;
    end else begin
      // a new violation wins over a clear in the same cycle
      flag_q <= (flag_q & ~clr_i) | viol_i;
      if (capture) begin
        fad_lo_q <= REG_W'({addr_i[FLO_MSB:FLO_LSB], {FLO_LSB{1'b0}}});
        fad_hi_q <= REG_W'(addr_i[FHI_MSB:FHI_LSB]);
      end
    end
  end

  // R7
  fad_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|flag_q) |=> ($stable(fad_lo_q) && $stable(fad_hi_q)));

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & ~$past(flag_q)) != '0) |-> $past(|viol_i));

  // R7
  fad_lo_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (fad_lo_q[FLO_LSB-1:0] == '0));

  // keep the width localparam referenced for readers of the field layout
  initial if (LO_W != 11) $display("fault log: low field is %0d bits", LO_W);

endmodule

// File: rtl/pgprot_monitor.sv
module pgprot_monitor
  import pgprot_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_RGN    = 4,
  parameter int PAGE_SHIFT = 10,
  parameter int REG_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_wr,
  input  logic [REG_W-1:0]      reg_wdata,
  input  logic                  reg_rd,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic [ADDR_W-1:0]     acc_addr,
  output logic                  irq_o
);

  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int PERM_W = $bits(perm_t);
  localparam int CTRL_W = PERM_W * NUM_RGN;
  localparam int IEN_W  = NUM_RGN + 1;

  logic [REG_W-1:0]   first_q [NUM_RGN];
  logic [REG_W-1:0]   last_q  [NUM_RGN];
  logic [CTRL_W-1:0]  perm_q;
  logic [IEN_W-1:0]   ien_q;
  logic [NUM_RGN-1:0] flag_q;
  logic [REG_W-1:0]   fad_lo_q;
  logic [REG_W-1:0]   fad_hi_q;
  logic [NUM_RGN-1:0] viol;
  logic [NUM_RGN-1:0] clr;
  logic [NUM_RGN-1:0] armed;
  logic [PAGE_W-1:0]  acc_page;
  logic [REG_W-1:0]   rd_val;

  assign acc_page = acc_addr[ADDR_W-1:PAGE_SHIFT];

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_RGN; k++) begin
        first_q[k] <= '0;
        last_q[k]  <= '0;
      end
      perm_q <= '0;
      ien_q  <= '0;
    end else if (reg_wr) begin
      for (int k = 0; k < NUM_RGN; k++) begin
        if (reg_addr == first_ofs(k)) first_q[k] <= reg_wdata;
        if (reg_addr == last_ofs(k))  last_q[k]  <= reg_wdata;
      end
      if (reg_addr == OFS_PERM) perm_q <= reg_wdata[CTRL_W-1:0];
      if (reg_addr == OFS_IEN)  ien_q  <= reg_wdata[IEN_W-1:0];
    end
  end

  // one comparator per range
  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    pgprot_range_match #(
      .PAGE_W(PAGE_W),
      .REG_W (REG_W)
    ) u_match (
      .page_i (acc_page),
      .first_i(first_q[g]),
      .last_i (last_q[g]),
      .perm_i (perm_t'(perm_q[PERM_W*g +: PERM_W])),
      .valid_i(acc_valid),
      .write_i(acc_write),
      .viol_o (viol[g])
    );
  end

  assign clr = (reg_wr && reg_addr == OFS_FLAG)
             ? (reg_wdata[NUM_RGN-1:0] | {NUM_RGN{reg_wdata[NUM_RGN]}})
             : '0;

  pgprot_fault_log #(
    .NUM_RGN(NUM_RGN),
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W)
  ) u_log (
    .clk     (clk),
    .rst     (rst),
    .viol_i  (viol),
    .clr_i   (clr),
    .addr_i  (acc_addr),
    .flag_q  (flag_q),
    .fad_lo_q(fad_lo_q),
    .fad_hi_q(fad_hi_q)
  );

  // read mux
  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_RGN; k++) begin
      if (reg_addr == first_ofs(k)) rd_val = first_q[k];
      if (reg_addr == last_ofs(k))  rd_val = last_q[k];
    end
    case (reg_addr)
      OFS_PERM:  rd_val = REG_W'(perm_q);
      OFS_IEN:   rd_val = REG_W'(ien_q);
      OFS_FLAG:  rd_val = REG_W'({|flag_q, flag_q});
      OFS_FADLO: rd_val = fad_lo_q;
      OFS_FADHI: rd_val = fad_hi_q;
      default: ;
    endcase
  end

  assign armed = flag_q & (ien_q[NUM_RGN-1:0] | {NUM_RGN{ien_q[NUM_RGN]}});

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_val;
      irq_o <= |armed;
    end
  end

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q == '0) |=> !irq_o);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|flag_q));

  // R4
  perm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == OFS_PERM) |=> $stable(perm_q));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/sim_pgprot_monitor.sv
module sim_pgprot_monitor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        irq_o;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pgprot_monitor u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .irq_o(irq_o)
  );

  // {write, address, expected flag register}
  localparam int NV = 13;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 32'h0000_4000, 5'h11},  // R3 lower bound, read denied
    {1'b0, 32'h0000_7FFF, 5'h11},  // R3 upper bound inclusive
    {1'b0, 32'h0000_8000, 5'h00},  // R3 one page past end
    {1'b0, 32'h0000_3FFF, 5'h00},  // R3 one byte before start
    {1'b1, 32'h0000_4000, 5'h00},  // R4 write allowed in range 0
    {1'b1, 32'h0004_0000, 5'h12},  // R4 write denied in range 1
    {1'b0, 32'h0004_0000, 5'h00},  // R4 read allowed in range 1
    {1'b1, 32'h0004_0400, 5'h00},  // R3 single-page range, next page
    {1'b0, 32'h0008_0000, 5'h14},  // R4 both denied, read
    {1'b1, 32'h000B_FC00, 5'h14},  // R4 both denied, write
    {1'b0, 32'h0010_0000, 5'h00},  // R4 field 00 disables, read
    {1'b1, 32'h0010_0000, 5'h00},  // R4 field 00 disables, write
    {1'b0, 32'h0400_4000, 5'h00}   // R3 page bits above 16 set
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic access(input logic w, input logic [31:0] a);
    acc_valid = 1'b1; acc_write = w; acc_addr = a;
    tick();
    acc_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {15'b0, irq_o}, 16'h0000);
    rd(6'h00, d); chk("R1 first0", d, 16'h0000);
    rd(6'h0E, d); chk("R1 last3", d, 16'h0000);
    rd(6'h10, d); chk("R1 perm", d, 16'h0000);
    rd(6'h1C, d); chk("R1 ien", d, 16'h0000);
    rd(6'h1E, d); chk("R1 flag", d, 16'h0000);
    rd(6'h22, d); chk("R1 fadlo", d, 16'h0000);
    rd(6'h24, d); chk("R1 fadhi", d, 16'h0000);

    // R2 range setup and readback
    wr(6'h00, 16'h0010); wr(6'h02, 16'h001F);
    wr(6'h04, 16'h0100); wr(6'h06, 16'h0100);
    wr(6'h08, 16'h0200); wr(6'h0A, 16'h02FF);
    wr(6'h0C, 16'h0400); wr(6'h0E, 16'h04FF);
    rd(6'h04, d); chk("R2 first1", d, 16'h0100);
    rd(6'h0A, d); chk("R2 last2", d, 16'h02FF);
    rd(6'h02, d); chk("R2 last0", d, 16'h001F);
    // R4 permissions: r0=01 r1=10 r2=11 r3=00, upper byte dropped
    wr(6'h10, 16'hFF39);
    rd(6'h10, d); chk("R4 perm upper", d, 16'h0039);

    // table walk (R3 R4 R5)
    for (int i = 0; i < NV; i++) begin
      wr(6'h1E, 16'h001F);
      access(VEC[i][37], VEC[i][36:5]);
      rd(6'h1E, d);
      chk($sformatf("R5 vector %0d", i), d, {11'b0, VEC[i][4:0]});
    end

    // R7 fault address capture and hold, R6 partial clears
    wr(6'h1E, 16'h001F);
    wr(6'h0C, 16'h8000); wr(6'h0E, 16'hFFFF);
    wr(6'h10, 16'h00F9);
    access(1'b0, 32'h03FF_FFE0);
    rd(6'h1E, d); chk("R5 high range flag", d, 16'h0018);
    rd(6'h22, d); chk("R7 fadlo", d, 16'hFFE0);
    rd(6'h24, d); chk("R7 fadhi", d, 16'h03FF);
    access(1'b0, 32'h0000_4000);
    rd(6'h1E, d); chk("R6 two flags", d, 16'h0019);
    rd(6'h22, d); chk("R7 fadlo held", d, 16'hFFE0);
    wr(6'h1E, 16'h0008);
    rd(6'h1E, d); chk("R6 clear bit3 only", d, 16'h0011);
    wr(6'h22, 16'h1234);
    rd(6'h22, d); chk("R7 write ignored", d, 16'hFFE0);
    rd(6'h24, d); chk("R7 fadhi held", d, 16'h03FF);
    wr(6'h1E, 16'h0000);
    rd(6'h1E, d); chk("R6 write zero no effect", d, 16'h0011);
    wr(6'h1E, 16'h0001);
    rd(6'h1E, d); chk("R6 cleared", d, 16'h0000);
    access(1'b0, 32'h0000_7FFF);
    rd(6'h22, d); chk("R7 recapture lo", d, 16'h7FE0);
    rd(6'h24, d); chk("R7 recapture hi", d, 16'h0000);

    // R5 overlap: range 3 covers page 0x10, read denied
    wr(6'h0C, 16'h0010); wr(6'h0E, 16'h0010);
    wr(6'h10, 16'h0079);
    wr(6'h1E, 16'h0010);
    rd(6'h1E, d); chk("R6 bit4 clears all", d, 16'h0000);
    access(1'b0, 32'h0000_4000);
    rd(6'h1E, d); chk("R5 overlap", d, 16'h0019);
    wr(6'h1E, 16'h001F);
    access(1'b0, 32'h0000_4400);
    rd(6'h1E, d); chk("R5 overlap edge", d, 16'h0011);

    // R5 valid low ignored
    wr(6'h1E, 16'h001F);
    acc_valid = 1'b0; acc_write = 1'b0; acc_addr = 32'h0000_4000;
    tick();
    rd(6'h1E, d); chk("R5 valid low", d, 16'h0000);

    // R8 enable register width
    wr(6'h1C, 16'hFFFF);
    rd(6'h1C, d); chk("R8 ien upper", d, 16'h001F);

    // R9 irq timing with per-range enable
    wr(6'h1C, 16'h0001);
    access(1'b0, 32'h0000_5000);
    chk("R9 irq not yet", {15'b0, irq_o}, 16'h0000);
    tick();
    chk("R9 irq one cycle later", {15'b0, irq_o}, 16'h0001);
    wr(6'h1E, 16'h001F);
    chk("R9 irq still high at clear edge", {15'b0, irq_o}, 16'h0001);
    tick();
    chk("R9 irq falls", {15'b0, irq_o}, 16'h0000);
    // R9 global enable
    wr(6'h1C, 16'h0010);
    access(1'b1, 32'h0004_0000);
    tick();
    chk("R9 global enable", {15'b0, irq_o}, 16'h0001);
    wr(6'h1E, 16'h001F);
    tick();
    // R9 masked range
    wr(6'h1C, 16'h0004);
    access(1'b1, 32'h0004_0000);
    tick();
    chk("R9 masked", {15'b0, irq_o}, 16'h0000);
    rd(6'h1E, d); chk("R9 flag still set", d, 16'h0012);

    // R10 unassigned offset
    rd(6'h30, d); chk("R10 unassigned", d, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule